// File: doc/BRIEF.md
# Oversampling UART Receiver with False-Start Rejection

This block turns an asynchronous serial line into parallel characters. It runs from a clock-enable pulse at sixteen times the bit rate. The incoming line passes through a two-flop synchronizer. After a falling edge the receiver waits half a bit and looks at the line again. If the line is high by then, the edge is treated as noise and dropped. Otherwise each later bit is sampled once, near its centre. The assembled character is then handed to a one-entry output holding stage.

Character length (5 to 8 bits) and parity (none, even or odd) come from static configuration inputs. The transmitter side uses the same settings. Each delivered character carries three tags:

- a parity-error flag;
- a framing-error flag;
- a break indication.

A separate overrun flag records that a character was lost because the consumer had not yet taken the previous one. A loopback select lets the receiver listen to a transmitter output instead of the external pin.

Top module: `uart_rx_core`

## Requirements
- R1: `cfg_len` selects the data length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. Data arrives least significant bit first. It is presented right-aligned on `out_data`, and the bits above the length read zero.
- R2: The selected serial source reaches the receive logic through a two-stage synchronizer that resets to the idle (high) level. A change on the line therefore acts on the receiver two clocks later.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_even` = 1 the data plus parity must hold an even number of ones; with 0, an odd number. A mismatch sets `out_perr`. With `cfg_par_en` = 0, `out_perr` is always 0.
- R4: In the idle state, a `tick16` cycle that sees the line low starts a candidate start bit. The line is looked at again on the 8th tick after that. If it is high then, the receiver returns to idle and delivers no character.
- R5: Each data bit, the parity bit and the first stop bit are sampled once, 16 ticks after the previous sample point. `out_ferr` is set when the first stop bit samples low. Further stop bits are not checked.
- R6: When every data bit, the parity bit (if enabled) and the stop bit sample low, `out_brk` and `out_ferr` are set and `out_data` is zero. The receiver then stays inactive until the line samples high on a tick.
- R7: With `loop_en` = 1 the receiver listens to `loop_src`, and activity on `serial_in` has no effect. With `loop_en` = 0 it listens to `serial_in`.
- R8: Suppose a character completes while `out_valid` is 1 and `rd_ack` is 0 in that cycle. Then the held character is kept unchanged, the new one is discarded and `out_ovr` becomes 1. `out_ovr` clears on the next `rd_ack`.
- R9: After reset, `out_valid` and `out_ovr` are 0 and `out_data` is zero. `out_valid` rises on the clock after the stop-bit sample. A `rd_ack` pulse while valid clears `out_valid` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| serial_in | input | 1 | External serial line, idle high |
| loop_en | input | 1 | 1 = receive from `loop_src` instead of `serial_in` |
| loop_src | input | 1 | Transmitter output used in loopback |
| cfg_len | input | 2 | Data length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rd_ack | input | 1 | Consumer takes the held character |
| out_valid | output | 1 | A received character is held |
| out_data | output | 8 | Received data, right-aligned |
| out_perr | output | 1 | Parity error tag of the held character |
| out_ferr | output | 1 | Framing error tag of the held character |
| out_brk | output | 1 | Break tag of the held character |
| out_ovr | output | 1 | A character was lost while one was held |

## Verification
The assertions assume that `cfg_len`, `cfg_par_en` and `cfg_par_even` stay constant while a character is being received. They also assume that `tick16` is a single-cycle pulse that repeats no faster than every second clock. The bench changes configuration only while the line is idle and no frame is in progress. It raises `tick16` on every fourth clock. It holds each serial bit for exactly sixteen ticks, so every sample point falls well inside a bit. The one exception is deliberately short low pulses used to provoke false starts.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the oversampling serial receiver.
// Assumes characters never exceed CHAR_W bits of data.
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_BITS,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
// Module: source select and metastability synchronizer.
// Picks the loopback source or the pin, then passes the result through
// STAGES flops that reset to the idle-high level.
// Assumes both sources idle high.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic loop_in,
    input  logic loop_en,
    output logic line_out
);

    logic             src_sel;
    logic [STAGES-1:0] chain;

    // Choose the line the receiver listens to.
    assign src_sel = loop_en ? loop_in : pin_in;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // One synchronizer stage; idle level after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= src_sel;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign line_out = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
// Module: start qualification, bit sampling and character assembly.
// Works on the synchronized line and the 16x tick. A falling level is rechecked
// half a bit later; every further bit is sampled one bit-time after the last.
// Produces a one-cycle done pulse with the character and its error tags.
// Assumes the configuration is stable for the duration of a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] cfg_len,
    input  logic       par_en,
    input  logic       par_even,
    output logic       done,
    output rx_char_t   chr
);

    localparam int               CNT_W    = $clog2(OVS);
    localparam int               IDX_W    = $clog2(CHAR_W + 3);
    localparam logic [CNT_W-1:0] MID_LAST = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(OVS - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              zero_acc;

    logic [IDX_W-1:0]  n_data;
    logic [IDX_W-1:0]  stop_idx;
    logic [IDX_W-1:0]  shamt;
    logic [CHAR_W-1:0] aligned;
    logic              brk_now;

    // Frame geometry from the configuration.
    assign n_data   = IDX_W'(CHAR_W - 3) + IDX_W'(cfg_len);
    assign stop_idx = n_data + IDX_W'(par_en);
    assign shamt    = IDX_W'(CHAR_W) - n_data;
    // Shifted-in data sits at the top; move it down to bit 0.
    assign aligned  = shreg >> shamt;
    assign brk_now  = zero_acc & ~line;

    // Receive state machine and bit assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_HUNT;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            zero_acc <= 1'b0;
            done     <= 1'b0;
            chr      <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RX_HUNT: begin
                    if (tick && !line) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt != MID_LAST) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (line) begin
                            state <= RX_HUNT;
                        end else begin
                            state    <= RX_BITS;
                            cnt      <= '0;
                            idx      <= '0;
                            shreg    <= '0;
                            par_acc  <= 1'b0;
                            zero_acc <= 1'b1;
                        end
                    end
                end
                RX_BITS: begin
                    if (tick) begin
                        if (cnt != BIT_LAST) begin
                            cnt <= cnt + CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            if (idx < n_data) begin
                                shreg    <= {line, shreg[CHAR_W-1:1]};
                                par_acc  <= par_acc ^ line;
                                zero_acc <= zero_acc & ~line;
                                idx      <= idx + IDX_W'(1);
                            end else if (idx != stop_idx) begin
                                par_acc  <= par_acc ^ line;
                                zero_acc <= zero_acc & ~line;
                                idx      <= idx + IDX_W'(1);
                            end else begin
                                done      <= 1'b1;
                                chr.data  <= aligned;
                                chr.perr  <= par_en & (par_acc ^ ~par_even);
                                chr.ferr  <= ~line;
                                chr.brk   <= brk_now;
                                state     <= brk_now ? RX_BRKWAIT : RX_HUNT;
                            end
                        end
                    end
                end
                RX_BRKWAIT: begin
                    if (tick && line) begin
                        state <= RX_HUNT;
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_hold.sv
// Module: one-entry output holding stage with overrun detection.
// Loads a finished character when empty or when it is taken in the same cycle;
// otherwise keeps the older character and raises the overrun flag.
// Assumes done is a single-cycle pulse.
module uart_rx_hold
    import uart_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     done,
    input  rx_char_t chr_in,
    input  logic     ack,
    output logic     valid,
    output rx_char_t chr_q,
    output logic     ovr
);

    // Holding register, valid bit and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            chr_q <= '0;
            ovr   <= 1'b0;
        end else if (done && (!valid || ack)) begin
            valid <= 1'b1;
            chr_q <= chr_in;
            ovr   <= 1'b0;
        end else if (done) begin
            ovr   <= 1'b1;
        end else if (ack) begin
            valid <= 1'b0;
            ovr   <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_core.sv
// Module: top of the oversampling serial receiver.
// Chains the source select and synchronizer, the frame engine and the
// output holding stage. Assumes tick16 is a single-cycle enable at 16x the
// bit rate and the configuration changes only between frames.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              serial_in,
    input  logic              loop_en,
    input  logic              loop_src,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              rd_ack,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_perr,
    output logic              out_ferr,
    output logic              out_brk,
    output logic              out_ovr
);

    logic     rx_line;
    logic     frm_done;
    rx_char_t frm_chr;
    rx_char_t held_chr;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (serial_in),
        .loop_in  (loop_src),
        .loop_en  (loop_en),
        .line_out (rx_line)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .line     (rx_line),
        .cfg_len  (cfg_len),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .done     (frm_done),
        .chr      (frm_chr)
    );

    uart_rx_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (frm_done),
        .chr_in (frm_chr),
        .ack    (rd_ack),
        .valid  (out_valid),
        .chr_q  (held_chr),
        .ovr    (out_ovr)
    );

    // Present the held character and its tags on the ports.
    assign out_data = held_chr.data;
    assign out_perr = held_chr.perr;
    assign out_ferr = held_chr.ferr;
    assign out_brk  = held_chr.brk;

endmodule

// File: rtl/uart_rx_chk.sv
// Module: property checker bound to uart_rx_core.
// Assumes configuration is stable within a frame.
module uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_len,
    input logic       cfg_par_en,
    input logic       rd_ack,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_ferr,
    input logic       out_brk,
    input logic       out_ovr,
    input logic       frm_done,
    input logic       frm_perr,
    input logic [7:0] frm_data
);

    assert_len5_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && cfg_len == 2'b00 |-> frm_data[7:5] == 3'b000);

    assert_no_perr_without_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done && !cfg_par_en |-> !frm_perr);

    assert_break_tags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_brk |-> out_ferr && out_data == 8'h00);

    assert_overrun_keeps_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && frm_done && !rd_ack |=> out_ovr && out_valid && $stable(out_data));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && rd_ack && !frm_done |=> !out_valid && !out_ovr);

endmodule

bind uart_rx_core uart_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_len    (cfg_len),
    .cfg_par_en (cfg_par_en),
    .rd_ack     (rd_ack),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ferr   (out_ferr),
    .out_brk    (out_brk),
    .out_ovr    (out_ovr),
    .frm_done   (frm_done),
    .frm_perr   (frm_chr.perr),
    .frm_data   (frm_chr.data)
);

// File: tb/tb_uart_rx_core.sv
// Bench: behavioural per-clock reference model plus directed frame checks.
module tb_uart_rx_core;

    localparam int BITCLK = 64;   // 16 ticks x 4 clocks per tick

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       serial_in = 1'b1;
    logic       loop_en = 1'b0;
    logic       loop_src = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       rd_ack = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_perr, out_ferr, out_brk, out_ovr;

    int checks = 0;
    int fails = 0;
    int prints = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    uart_rx_core dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .serial_in(serial_in),
        .loop_en(loop_en), .loop_src(loop_src), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even), .rd_ack(rd_ack),
        .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
        .out_ferr(out_ferr), .out_brk(out_brk), .out_ovr(out_ovr)
    );

    // Tick generator: one enable every fourth clock.
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph++;
            tick16 = (ph % 4 == 0);
        end
    end

    // ---------------- reference model ----------------
    int m_s1, m_s2, m_state, m_cnt, m_idx, m_acc, m_ones, m_zero;
    int m_done, m_dat, m_perr, m_ferr, m_brk;
    int m_valid, m_qdat, m_qperr, m_qferr, m_qbrk, m_ovr;

    always @(posedge clk) begin
        int line, nd;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_state = 0; m_cnt = 0; m_idx = 0;
            m_acc = 0; m_ones = 0; m_zero = 0; m_done = 0;
            m_dat = 0; m_perr = 0; m_ferr = 0; m_brk = 0;
            m_valid = 0; m_qdat = 0; m_qperr = 0; m_qferr = 0; m_qbrk = 0; m_ovr = 0;
        end else begin
            // output holding stage, fed by last cycle's completion
            if (m_done != 0) begin
                if (m_valid == 0 || rd_ack) begin
                    m_valid = 1; m_qdat = m_dat; m_qperr = m_perr;
                    m_qferr = m_ferr; m_qbrk = m_brk; m_ovr = 0;
                end else begin
                    m_ovr = 1;
                end
            end else if (rd_ack) begin
                m_valid = 0; m_ovr = 0;
            end
            // frame engine: 0 idle, 1 start check, 2 bits, 3 wait after break
            m_done = 0;
            line = m_s2;
            nd = 5 + int'(cfg_len);
            if (tick16) begin
                case (m_state)
                    0: if (line == 0) begin m_state = 1; m_cnt = 0; end
                    1: begin
                        if (m_cnt < 7) m_cnt++;
                        else if (line != 0) m_state = 0;
                        else begin
                            m_state = 2; m_cnt = 0; m_idx = 0;
                            m_acc = 0; m_ones = 0; m_zero = 1;
                        end
                    end
                    2: begin
                        if (m_cnt < 15) m_cnt++;
                        else begin
                            m_cnt = 0;
                            if (m_idx < nd) begin
                                m_acc = m_acc + (line << m_idx);
                                m_ones += line;
                                if (line != 0) m_zero = 0;
                                m_idx++;
                            end else if (cfg_par_en && m_idx == nd) begin
                                m_ones += line;
                                if (line != 0) m_zero = 0;
                                m_idx++;
                            end else begin
                                m_done = 1;
                                m_dat = m_acc;
                                if (!cfg_par_en) m_perr = 0;
                                else if (cfg_par_even) m_perr = m_ones % 2;
                                else m_perr = 1 - (m_ones % 2);
                                m_ferr = (line == 0);
                                m_brk = (m_zero != 0 && line == 0);
                                m_state = (m_brk != 0) ? 3 : 0;
                            end
                        end
                    end
                    default: if (line != 0) m_state = 0;
                endcase
            end
            // synchronizer
            m_s2 = m_s1;
            m_s1 = loop_en ? loop_src : serial_in;
        end
    end

    task automatic report(input string req, input string what, input int act, input int exp);
        fails++;
        if (prints < 40) begin
            prints++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (int'(out_valid) != m_valid) report("R2", "out_valid vs model", out_valid, m_valid);
            if (int'(out_ovr) != m_ovr) report("R8", "out_ovr vs model", out_ovr, m_ovr);
            if (m_valid != 0) begin
                if (int'(out_data) != m_qdat) report("R1", "out_data vs model", out_data, m_qdat);
                if (int'(out_perr) != m_qperr) report("R3", "out_perr vs model", out_perr, m_qperr);
                if (int'(out_ferr) != m_qferr) report("R5", "out_ferr vs model", out_ferr, m_qferr);
                if (int'(out_brk) != m_qbrk) report("R6", "out_brk vs model", out_brk, m_qbrk);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) report(req, what, act, exp);
    endtask

    task automatic drive(input bit v, input int clocks, input bit to_loop);
        @(negedge clk);
        if (to_loop) loop_src = v; else serial_in = v;
        repeat (clocks - 1) @(negedge clk);
    endtask

    task automatic send_char(input bit to_loop, input int data, input int nd,
                             input bit pen, input bit even, input bit flip, input bit stop);
        int ones = 0;
        drive(1'b0, BITCLK, to_loop);
        for (int i = 0; i < nd; i++) begin
            drive(data[i], BITCLK, to_loop);
            ones += data[i];
        end
        if (pen) drive(((even ? ones % 2 : 1 - ones % 2) != 0) ^ flip, BITCLK, to_loop);
        drive(stop, BITCLK, to_loop);
        drive(1'b1, BITCLK, to_loop);
    endtask

    task automatic take(input string req, input int data, input bit perr,
                        input bit ferr, input bit brk);
        int waited = 0;
        while (!out_valid && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        check(req, "out_valid before take", out_valid, 1);
        check(req, "out_data", out_data, data);
        check(req, "out_perr", out_perr, perr);
        check(req, "out_ferr", out_ferr, ferr);
        check(req, "out_brk", out_brk, brk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check("R9", "out_valid after rd_ack", out_valid, 0);
    endtask

    task automatic set_cfg(input int len, input bit pen, input bit even);
        @(negedge clk);
        cfg_len = 2'(len - 5);
        cfg_par_en = pen;
        cfg_par_even = even;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset out_valid", out_valid, 0);
        check("R9", "reset out_ovr", out_ovr, 0);
        check("R9", "reset out_data", out_data, 0);
        repeat (20) @(negedge clk);

        // R1: all four lengths, no parity
        set_cfg(8, 0, 0); send_char(0, 8'hA5, 8, 0, 0, 0, 1); take("R1", 8'hA5, 0, 0, 0);
        set_cfg(5, 0, 0); send_char(0, 8'h1D, 5, 0, 0, 0, 1); take("R1", 8'h1D, 0, 0, 0);
        set_cfg(6, 0, 0); send_char(0, 8'h2A, 6, 0, 0, 0, 1); take("R1", 8'h2A, 0, 0, 0);
        set_cfg(7, 0, 0); send_char(0, 8'h55, 7, 0, 0, 0, 1); take("R1", 8'h55, 0, 0, 0);

        // R3: parity even/odd, good and bad
        set_cfg(8, 1, 1); send_char(0, 8'h5A, 8, 1, 1, 0, 1); take("R3", 8'h5A, 0, 0, 0);
        send_char(0, 8'h5B, 8, 1, 1, 1, 1); take("R3", 8'h5B, 1, 0, 0);
        set_cfg(7, 1, 0); send_char(0, 8'h33, 7, 1, 0, 0, 1); take("R3", 8'h33, 0, 0, 0);
        send_char(0, 8'h31, 7, 1, 0, 1, 1); take("R3", 8'h31, 1, 0, 0);

        // R5: stop bit low gives a framing error
        set_cfg(8, 0, 0); send_char(0, 8'h3C, 8, 0, 0, 0, 0); take("R5", 8'h3C, 0, 1, 0);
        repeat (200) @(negedge clk);
        check("R4", "no character after framing tail", out_valid, 0);

        // R4: short low pulses are rejected
        drive(1'b0, 12, 0); drive(1'b1, 300, 0);
        check("R4", "glitch produces no character", out_valid, 0);
        drive(1'b0, 20, 0); drive(1'b1, 300, 0);
        check("R4", "second glitch produces no character", out_valid, 0);
        send_char(0, 8'hC3, 8, 0, 0, 0, 1); take("R4", 8'hC3, 0, 0, 0);

        // R6: break then wait for line high
        set_cfg(8, 1, 1);
        drive(1'b0, 12 * BITCLK, 0);
        take("R6", 8'h00, 1'b0, 1, 1);
        drive(1'b0, 10 * BITCLK, 0);
        check("R6", "no character while line stays low", out_valid, 0);
        drive(1'b1, 3 * BITCLK, 0);
        check("R6", "no character on return high", out_valid, 0);
        send_char(0, 8'h81, 8, 1, 1, 0, 1); take("R6", 8'h81, 0, 0, 0);

        // R8: overrun keeps the older character
        set_cfg(8, 0, 0);
        send_char(0, 8'h11, 8, 0, 0, 0, 1);
        send_char(0, 8'h22, 8, 0, 0, 0, 1);
        check("R8", "overrun flag", out_ovr, 1);
        take("R8", 8'h11, 0, 0, 0);
        check("R8", "overrun cleared by ack", out_ovr, 0);
        send_char(0, 8'h44, 8, 0, 0, 0, 1); take("R8", 8'h44, 0, 0, 0);

        // R7: loopback source and pin isolation
        @(negedge clk); loop_en = 1'b1;
        send_char(1, 8'h96, 8, 0, 0, 0, 1); take("R7", 8'h96, 0, 0, 0);
        send_char(0, 8'h0F, 8, 0, 0, 0, 1);
        check("R7", "pin ignored in loopback", out_valid, 0);
        @(negedge clk); loop_en = 1'b0;
        send_char(0, 8'hE7, 8, 0, 0, 0, 1); take("R7", 8'hE7, 0, 0, 0);

        repeat (50) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule